// File: doc/BRIEF.md
# Power-Down Mode and Wake Controller

This block steps a small processor core between running, two sleep levels and a post-reset warm-up phase. It takes sleep requests from instruction decode, the chip reset, and, for each interrupt source, a request flag and an enable flag, together with the global interrupt enable. From these it drives a CPU clock enable, a main oscillator enable and a peripheral power-down signal.

The light sleep level gates only the CPU clock. The deep sleep level also stops the oscillator and powers the peripherals down. An enabled interrupt source releases either level and produces a one-cycle wake pulse. With the pulse come the winning source and a flag that says whether the core should enter a service routine. When that flag is set, the block lets two instructions retire and then tells the core to vector.

After reset the CPU clock stays off for a fixed, parameterised number of cycles while the oscillator settles. Source 0 can never wake the core. Sources 2 and 7 are quasi-interrupts: they wake the core but never lead to a service routine.

Top module: `pd_wake_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pd_state` is 2'b11 (warm-up), `cpu_clk_en` is 0, `osc_en` is 1 and `periph_pd` is 0. `wake_valid`, `stop_err`, `svc_pending` and `svc_take` are all 0.
- R2: After `rst` falls, `cpu_clk_en` stays 0 when sampled after each of the first STAB_CYC rising edges. It is 1 after the next edge, when `pd_state` becomes 2'b00 (run).
- R3: In run, `req_idle` moves the block to `pd_state` 2'b01 (light sleep), with `cpu_clk_en`=0, `osc_en`=1 and `periph_pd`=0. If `req_idle` and `req_stop` are both high, light sleep is chosen.
- R4: In run, with `ext_clk_sel`=0 and `req_idle`=0, `req_stop` moves the block to `pd_state` 2'b10 (deep sleep), with `cpu_clk_en`=0, `osc_en`=0 and `periph_pd`=1.
- R5: A stop request made while `ext_clk_sel`=1 is refused. The block stays in run and pulses `stop_err` for exactly one cycle.
- R6: A source i wakes the block from either sleep level only when `irq_req[i]` and `irq_en[i]` are both 1 and i is not 0. A wake returns the block to run and pulses `wake_valid` for one cycle. A pending source that is disabled, and source 0 even when enabled, leave the sleep level unchanged.
- R7: If an enabled source that is able to wake the block is already pending when a sleep request arrives in run, the block stays in run and gives the wake pulse instead of sleeping.
- R8: During the wake pulse, `wake_cause` is one-hot on the lowest-indexed source that caused the wake. `wake_vector` equals `ime` AND NOT quasi(cause), where sources 2 and 7 are quasi.
- R9: After a wake with `wake_vector`=1, `svc_pending` is 1 until the second `instr_retire` pulse. `svc_take` is then high for exactly one cycle, and `svc_pending` clears. A wake with `wake_vector`=0 gives no `svc_take`.
- R10: Reset taken in either sleep level returns the block to warm-up (2'b11) with the oscillator running.
- R11: Sleep requests that arrive outside run (in either sleep level or in warm-up) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; starts warm-up |
| req_idle | input | 1 | Light-sleep request from decode |
| req_stop | input | 1 | Deep-sleep request from decode |
| ext_clk_sel | input | 1 | External clock source selected |
| ime | input | 1 | Global interrupt enable |
| irq_req | input | NUM_SRC | Per-source request flags |
| irq_en | input | NUM_SRC | Per-source enable flags |
| instr_retire | input | 1 | One pulse per retired instruction |
| pd_state | output | 2 | 00 run, 01 light sleep, 10 deep sleep, 11 warm-up |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| osc_en | output | 1 | Main oscillator enable |
| periph_pd | output | 1 | Peripheral power-down |
| stop_err | output | 1 | One-cycle pulse when a stop request is refused |
| wake_valid | output | 1 | One-cycle wake pulse |
| wake_vector | output | 1 | Service routine wanted after this wake |
| wake_cause | output | NUM_SRC | One-hot winning source of the wake |
| svc_pending | output | 1 | Waiting for two instructions before vectoring |
| svc_take | output | 1 | One-cycle pulse: vector now |

## Verification
A wrong state register shows at once in the clock, oscillator and power-down outputs. The wrong level is visible on the first cycle after the edge that went wrong. A warm-up counter that is off by one moves the rising edge of `cpu_clk_en` by one cycle, so an exact edge count after reset exposes it. Bad wake qualification, such as source 0 waking the core or a disabled source being accepted, shows as a sleep level that should have held but did not, one cycle after the request is raised. The sweep covers every source, both values of `ime` and both sleep levels. Errors in the vector decision or in the instruction counter show at `wake_vector`, or in a misplaced or missing `svc_take`, within two instructions of the wake.

// File: rtl/pd_wake_pkg.sv
package pd_wake_pkg;

    typedef enum logic [1:0] {
        PD_RUN   = 2'b00,
        PD_LIGHT = 2'b01,
        PD_DEEP  = 2'b10,
        PD_WARM  = 2'b11
    } pd_state_e;

    typedef struct packed {
        logic cpu_clk_en;
        logic osc_en;
        logic periph_pd;
    } pd_drive_t;

    typedef enum logic [1:0] {
        REQ_NONE  = 2'b00,
        REQ_LIGHT = 2'b01,
        REQ_DEEP  = 2'b10
    } pd_req_e;

    function automatic pd_drive_t pd_drive(input pd_state_e st);
        pd_drive_t d;
        d.cpu_clk_en = (st == PD_RUN);
        d.osc_en     = (st != PD_DEEP);
        d.periph_pd  = (st == PD_DEEP);
        return d;
    endfunction

    function automatic pd_req_e pd_pick_req(input logic idle_r, input logic stop_r);
        if (idle_r)      return REQ_LIGHT;
        else if (stop_r) return REQ_DEEP;
        else             return REQ_NONE;
    endfunction

endpackage

// File: rtl/pd_warmup_timer.sv
module pd_warmup_timer #(
    parameter int STAB_CYC = 131072,
    localparam int CW = $clog2(STAB_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(STAB_CYC));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + CW'(1);
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(STAB_CYC));

endmodule

// File: rtl/pd_wake_eval.sv
module pd_wake_eval #(
    parameter int NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0] NOWAKE_MASK = 'b1,
    parameter logic [NUM_SRC-1:0] QUASI_MASK  = 'h84
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               ime,
    output logic               hit,
    output logic [NUM_SRC-1:0] cause,
    output logic               vec
);
    logic [NUM_SRC-1:0] cand;
    logic [NUM_SRC-1:0] vec_ok;

    assign cand  = irq_req & irq_en & ~NOWAKE_MASK;
    assign hit   = |cand;
    assign cause = cand & (~cand + NUM_SRC'(1));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (QUASI_MASK[g]) begin : g_quasi
            assign vec_ok[g] = 1'b0;
        end else begin : g_real
            assign vec_ok[g] = cause[g];
        end
    end

    assign vec = ime & (|vec_ok);

    p_cause_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause) && (hit == (cause != '0)));

    p_cause_from_enabled_r6: assert property (@(posedge clk) disable iff (rst)
        (cause & ~(irq_req & irq_en)) == '0);

endmodule

// File: rtl/pd_svc_tracker.sv
module pd_svc_tracker #(
    parameter int NUM_INSTR = 2,
    localparam int TW = $clog2(NUM_INSTR + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic retire,
    output logic pending,
    output logic take
);
    logic [TW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            take    <= 1'b0;
            seen    <= '0;
        end else begin
            take <= 1'b0;
            if (start) begin
                pending <= 1'b1;
                seen    <= '0;
            end else if (pending && retire) begin
                if (seen == TW'(NUM_INSTR - 1)) begin
                    take    <= 1'b1;
                    pending <= 1'b0;
                    seen    <= '0;
                end else begin
                    seen <= seen + TW'(1);
                end
            end
        end
    end

    p_take_after_wait_r9: assert property (@(posedge clk) disable iff (rst)
        take |-> (!pending && $past(pending)));

    p_take_needs_retire_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(take) |-> $past(retire));

endmodule

// File: rtl/pd_wake_ctrl.sv
module pd_wake_ctrl
    import pd_wake_pkg::*;
#(
    parameter int NUM_SRC   = 8,
    parameter int STAB_CYC  = 131072,
    parameter int NUM_INSTR = 2,
    parameter logic [NUM_SRC-1:0] NOWAKE_MASK = 'b1,
    parameter logic [NUM_SRC-1:0] QUASI_MASK  = 'h84
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_idle,
    input  logic               req_stop,
    input  logic               ext_clk_sel,
    input  logic               ime,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               instr_retire,
    output logic [1:0]         pd_state,
    output logic               cpu_clk_en,
    output logic               osc_en,
    output logic               periph_pd,
    output logic               stop_err,
    output logic               wake_valid,
    output logic               wake_vector,
    output logic [NUM_SRC-1:0] wake_cause,
    output logic               svc_pending,
    output logic               svc_take
);
    pd_state_e          state, state_nx;
    pd_req_e            req;
    pd_drive_t          drv;
    logic               warm_done;
    logic               hit;
    logic               vec;
    logic [NUM_SRC-1:0] cause;
    logic               wake_fire;
    logic               refuse;

    pd_warmup_timer #(.STAB_CYC(STAB_CYC)) i_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == PD_WARM),
        .done (warm_done)
    );

    pd_wake_eval #(
        .NUM_SRC    (NUM_SRC),
        .NOWAKE_MASK(NOWAKE_MASK),
        .QUASI_MASK (QUASI_MASK)
    ) i_eval (
        .clk    (clk),
        .rst    (rst),
        .irq_req(irq_req),
        .irq_en (irq_en),
        .ime    (ime),
        .hit    (hit),
        .cause  (cause),
        .vec    (vec)
    );

    assign req = pd_pick_req(req_idle, req_stop);

    always_comb begin
        state_nx  = state;
        wake_fire = 1'b0;
        refuse    = 1'b0;
        unique case (state)
            PD_WARM: begin
                if (warm_done) state_nx = PD_RUN;
            end
            PD_RUN: begin
                if (req == REQ_LIGHT) begin
                    if (hit) wake_fire = 1'b1;
                    else     state_nx  = PD_LIGHT;
                end else if (req == REQ_DEEP) begin
                    if (ext_clk_sel) refuse    = 1'b1;
                    else if (hit)    wake_fire = 1'b1;
                    else             state_nx  = PD_DEEP;
                end
            end
            PD_LIGHT, PD_DEEP: begin
                if (hit) begin
                    wake_fire = 1'b1;
                    state_nx  = PD_RUN;
                end
            end
            default: state_nx = PD_WARM;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= PD_WARM;
            stop_err    <= 1'b0;
            wake_valid  <= 1'b0;
            wake_vector <= 1'b0;
            wake_cause  <= '0;
        end else begin
            state      <= state_nx;
            stop_err   <= refuse;
            wake_valid <= wake_fire;
            if (wake_fire) begin
                wake_vector <= vec;
                wake_cause  <= cause;
            end else begin
                wake_vector <= 1'b0;
                wake_cause  <= '0;
            end
        end
    end

    pd_svc_tracker #(.NUM_INSTR(NUM_INSTR)) i_svc (
        .clk    (clk),
        .rst    (rst),
        .start  (wake_fire && vec),
        .retire (instr_retire),
        .pending(svc_pending),
        .take   (svc_take)
    );

    assign drv        = pd_drive(state);
    assign pd_state   = state;
    assign cpu_clk_en = drv.cpu_clk_en;
    assign osc_en     = drv.osc_en;
    assign periph_pd  = drv.periph_pd;

    p_sleep_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ((state == PD_LIGHT || state == PD_DEEP) && !(|(irq_req & irq_en & ~NOWAKE_MASK)))
        |=> (pd_state == $past(pd_state)));

    p_stop_refuse_r5: assert property (@(posedge clk) disable iff (rst)
        (state == PD_RUN && req_stop && !req_idle && ext_clk_sel)
        |=> (pd_state == 2'b00 && stop_err));

    p_wake_in_run_r6: assert property (@(posedge clk) disable iff (rst)
        wake_valid |-> (pd_state == 2'b00 && cpu_clk_en));

    p_warm_no_req_r11: assert property (@(posedge clk) disable iff (rst)
        (state == PD_WARM) |=> (pd_state == 2'b11 || pd_state == 2'b00));

endmodule

// File: tb/test_pd_wake_ctrl.sv
module test_pd_wake_ctrl;
    localparam int CLK_P   = 10;
    localparam int NSRC    = 8;
    localparam int STAB    = 20;

    logic clk = 1'b0;
    logic rst, req_idle, req_stop, ext_clk_sel, ime, instr_retire;
    logic [NSRC-1:0] irq_req, irq_en;
    logic [1:0] pd_state;
    logic cpu_clk_en, osc_en, periph_pd, stop_err, wake_valid, wake_vector;
    logic [NSRC-1:0] wake_cause;
    logic svc_pending, svc_take;

    int total = 0;
    int bad   = 0;

    always #(CLK_P/2) clk = ~clk;

    pd_wake_ctrl #(.NUM_SRC(NSRC), .STAB_CYC(STAB)) i_pd_wake_ctrl (
        .clk(clk), .rst(rst), .req_idle(req_idle), .req_stop(req_stop),
        .ext_clk_sel(ext_clk_sel), .ime(ime), .irq_req(irq_req), .irq_en(irq_en),
        .instr_retire(instr_retire), .pd_state(pd_state), .cpu_clk_en(cpu_clk_en),
        .osc_en(osc_en), .periph_pd(periph_pd), .stop_err(stop_err),
        .wake_valid(wake_valid), .wake_vector(wake_vector), .wake_cause(wake_cause),
        .svc_pending(svc_pending), .svc_take(svc_take)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_drive(input string tag, input logic [1:0] st);
        chk({tag, " state"}, pd_state, st);
        chk({tag, " clk"}, cpu_clk_en, st == 2'b00);
        chk({tag, " osc"}, osc_en, st != 2'b10);
        chk({tag, " pd"}, periph_pd, st == 2'b10);
    endtask

    task automatic do_reset_and_warm(input string tag);
        int n;
        rst = 1'b1;
        step();
        step();
        chk_drive({tag, " R1 in reset"}, 2'b11);
        chk({tag, " R1 wake"}, {wake_valid, stop_err, svc_pending, svc_take}, 4'b0);
        rst = 1'b0;
        n = 0;
        for (int k = 0; k < STAB + 10; k++) begin
            step();
            if (cpu_clk_en) break;
            n++;
            if (n == 1) chk_drive({tag, " R1 first cycle"}, 2'b11);
        end
        chk({tag, " R2 warm count"}, n, STAB);
        chk({tag, " R2 run state"}, pd_state, 2'b00);
    endtask

    task automatic enter(input logic deep);
        req_idle = !deep;
        req_stop = deep;
        step();
        req_idle = 1'b0;
        req_stop = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req_idle = 0; req_stop = 0; ext_clk_sel = 0; ime = 0;
        instr_retire = 0; irq_req = '0; irq_en = '0;
        @(negedge clk);
        do_reset_and_warm("boot");

        // Sweep: every source, both ime values, both sleep levels (R3 R4 R6 R8 R9)
        for (int md = 0; md < 2; md++) begin
            for (int im = 0; im < 2; im++) begin
                for (int s = 0; s < NSRC; s++) begin
                    logic quasi, expv;
                    quasi = (s == 2) || (s == 7);
                    expv  = (im == 1) && !quasi && (s != 0);
                    ime = im[0];
                    irq_req = '0; irq_en = '0;
                    enter(md[0]);
                    chk_drive(md ? "R4 deep" : "R3 light", md ? 2'b10 : 2'b01);
                    irq_req[s] = 1'b1;
                    step();
                    step();
                    chk("R6 disabled holds", pd_state, md ? 2'b10 : 2'b01);
                    irq_en[s] = 1'b1;
                    step();
                    if (s == 0) begin
                        chk("R6 src0 no wake", {pd_state, wake_valid}, {(md ? 2'b10 : 2'b01), 1'b0});
                        step();
                        chk("R6 src0 still asleep", pd_state, md ? 2'b10 : 2'b01);
                        irq_req = 8'h01 | 8'h02; irq_en = 8'h03;
                        step();
                        chk("R8 cause skips src0", wake_cause, 8'h02);
                        irq_req = '0; irq_en = '0;
                        chk("R6 woken by src1", pd_state, 2'b00);
                        instr_retire = 1'b1;
                        step();
                        step();
                        instr_retire = 1'b0;
                        step();
                    end else begin
                        chk("R6 wake state", pd_state, 2'b00);
                        chk("R6 wake pulse", wake_valid, 1'b1);
                        chk("R8 cause", wake_cause, 32'(1 << s));
                        chk("R8 vector", wake_vector, expv);
                        chk("R9 pending", svc_pending, expv);
                        irq_req = '0; irq_en = '0;
                        instr_retire = 1'b1;
                        step();
                        chk("R6 pulse ends", wake_valid, 1'b0);
                        chk("R9 no early take", svc_take, 1'b0);
                        step();
                        instr_retire = 1'b0;
                        chk("R9 take", svc_take, expv);
                        chk("R9 pending cleared", svc_pending, 1'b0);
                        step();
                        chk("R9 take one cycle", svc_take, 1'b0);
                    end
                end
            end
        end

        // R7: already pending source releases immediately
        ime = 1'b0;
        irq_req = 8'h08; irq_en = 8'h08;
        enter(1'b0);
        chk("R7 idle immediate", {pd_state, wake_valid}, {2'b00, 1'b1});
        chk("R7 cause", wake_cause, 8'h08);
        enter(1'b1);
        chk("R7 stop immediate", {pd_state, wake_valid}, {2'b00, 1'b1});
        irq_req = 8'h01; irq_en = 8'h01;
        enter(1'b0);
        chk("R7 src0 does not release", {pd_state, wake_valid}, {2'b01, 1'b0});
        irq_req = 8'h10; irq_en = 8'h10;
        step();
        irq_req = '0; irq_en = '0;
        step();

        // R5: stop refused with external clock
        ext_clk_sel = 1'b1;
        enter(1'b1);
        chk("R5 stays run", pd_state, 2'b00);
        chk("R5 err pulse", stop_err, 1'b1);
        step();
        chk("R5 err one cycle", stop_err, 1'b0);
        enter(1'b0);
        chk("R5 idle allowed", pd_state, 2'b01);
        chk("R5 no err", stop_err, 1'b0);
        ext_clk_sel = 1'b0;

        // R11: requests ignored while asleep
        req_stop = 1'b1;
        step();
        req_stop = 1'b0;
        chk("R11 stop ignored in light", pd_state, 2'b01);
        irq_req = 8'h20; irq_en = 8'h20;
        step();
        irq_req = '0; irq_en = '0;
        chk("R6 light woken", pd_state, 2'b00);
        // R3: both requests pick light sleep
        req_idle = 1'b1; req_stop = 1'b1;
        step();
        req_idle = 1'b0; req_stop = 1'b0;
        chk_drive("R3 both", 2'b01);
        irq_req = 8'h20; irq_en = 8'h20;
        step();
        irq_req = '0; irq_en = '0;

        // R10: reset from deep sleep
        enter(1'b1);
        chk("R10 deep", pd_state, 2'b10);
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk_drive("R10 back to warm", 2'b11);
        // R11: request during warm-up ignored
        req_idle = 1'b1;
        step();
        req_idle = 1'b0;
        chk("R11 warm ignores idle", pd_state, 2'b11);
        do_reset_and_warm("again");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule